// File: doc/BRIEF.md
# Video Decoder Port Router

This block sits between an external video decoder chip and a processor's video capture port. The decoder delivers an 8-bit luma bus and an 8-bit chroma bus, a pixel clock, and three timing signals: horizontal sync, vertical sync and an odd-field flag. The block registers the pixel and timing inputs on the rising edge of the decoder pixel clock. It then places them on the capture port pins.

Luma and chroma are packed into one 20-bit port word that has fixed zero padding. The port clock pins and control pins each carry a value and an output enable, so a high-impedance pin can be observed directly.

A single control register sets how the pins are driven and whether the decoder is held in reset. The register sits on the processor's external memory bus at one word address. It holds three bits:

- bit 0: decoder reset
- bit 1: clock pin direction
- bit 2: control pin direction

Top module: `vid_dec_router`

## Requirements
- R1: The register answers only at byte address 0xA00E0000; bus_addr[1:0] are ignored. A write to any other word changes nothing. A read of any other word never raises bus_rvalid.
- R2: A read of the register raises bus_rvalid for exactly the cycle after the read request. In that cycle bus_rdata[2:0] holds the register and bus_rdata[31:3] is zero.
- R3: After reset the register reads 0x01. The outputs are then: dec_reset = 1, both port clock enables = 1, all three control enables = 1, and port_data = 0.
- R4: Register bit 0 drives dec_reset, with 1 meaning reset asserted. A write changes dec_reset in the cycle after the write request.
- R5: With register bit 1 = 0, port_clk0 and port_clk1 both follow dec_pclk, and both enables are 1. With bit 1 = 1, both enables are 0.
- R6: With register bit 2 = 0, all three control enables are 1, and:
  - port_ctrl[0] is the registered horizontal sync;
  - port_ctrl[1] is the registered vertical sync;
  - port_ctrl[2] is the registered odd-field flag.
- R7: With register bit 2 = 1:
  - port_ctrl[1:0] = 2'b11, with both enables = 1;
  - port_ctrl_oe[2] = 0.
- R8: The port word is packed as follows:
  - port_data[19:12] is the registered chroma;
  - port_data[9:2] is the registered luma;
  - port_data[11:10] and port_data[1:0] are always 0.
- R9: Luma, chroma and the three sync inputs reach the port pins only after a rising edge of dec_pclk. Between edges the pins hold the values captured at the last edge.
- R10: Write data bits 31:3 have no effect. They always read back as 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset for both clock domains |
| bus_sel | input | 1 | Bus access request |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 32 | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid with bus_rvalid |
| bus_rvalid | output | 1 | Read data valid |
| dec_pclk | input | 1 | Decoder pixel clock |
| dec_luma | input | 8 | Decoder luma |
| dec_chroma | input | 8 | Decoder chroma |
| dec_hsync | input | 1 | Decoder horizontal sync |
| dec_vsync | input | 1 | Decoder vertical sync |
| dec_odd | input | 1 | Decoder odd-field flag |
| dec_reset | output | 1 | Reset to the decoder, 1 = asserted |
| port_clk0 | output | 1 | Capture port clock 0 value |
| port_clk0_oe | output | 1 | Capture port clock 0 enable |
| port_clk1 | output | 1 | Capture port clock 1 value |
| port_clk1_oe | output | 1 | Capture port clock 1 enable |
| port_ctrl | output | 3 | Capture port control pin values |
| port_ctrl_oe | output | 3 | Capture port control pin enables |
| port_data | output | 20 | Capture port data word |

## Verification
A register write that changes the control routing can land on the same edge at which the pixel clock captures new sync values. The bench aligns the pixel clock's rising edges with bus clock rising edges to make this happen. It issues the direction write and changes the sync and luma inputs ahead of that shared edge. After the edge it checks that the control pins show both the new routing and the newly captured sync values. It also checks that the data word carries the new luma.

// File: rtl/vdr_pkg.sv
package vdr_pkg;
  localparam int PIX_W  = 8;
  localparam int PAD_W  = 2;
  localparam int PORT_W = 2 * (PIX_W + PAD_W);
  localparam int CFG_W  = 3;
  localparam int SYNC_W = 3;

  typedef struct packed {
    logic ctrl_dir;  // bit 2
    logic clk_dir;   // bit 1
    logic dec_rst;   // bit 0
  } vdr_cfg_t;

  // Chroma in the upper half, luma in the lower half, each followed by zero padding.
  function automatic logic [PORT_W-1:0] pack_port(input logic [PIX_W-1:0] chroma,
                                                  input logic [PIX_W-1:0] luma);
    return {chroma, {PAD_W{1'b0}}, luma, {PAD_W{1'b0}}};
  endfunction

  function automatic logic [31:0] cfg_readback(input logic [CFG_W-1:0] cfg);
    return {{(32-CFG_W){1'b0}}, cfg};
  endfunction
endpackage

// File: rtl/vdr_ctrl_reg.sv
module vdr_ctrl_reg #(
  parameter int          AW    = 32,
  parameter int          DW    = 32,
  parameter int          CW    = vdr_pkg::CFG_W,
  parameter logic [31:0] BASE  = 32'hA00E_0000,
  parameter logic [CW-1:0] RST_VAL = 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sel,
  input  logic          wr,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic [CW-1:0] cfg_o,
  output logic [DW-1:0] rdata,
  output logic          rvalid
);
  logic          hit;
  logic          wr_hit;
  logic          rd_hit;
  logic [CW-1:0] cfg_q;

  assign hit    = (addr[AW-1:2] == BASE[AW-1:2]);
  assign wr_hit = sel && wr && hit;
  assign rd_hit = sel && !wr && hit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q  <= RST_VAL;
      rdata  <= '0;
      rvalid <= 1'b0;
    end else begin
      if (wr_hit) cfg_q <= wdata[CW-1:0];
      rvalid <= rd_hit;
      rdata  <= rd_hit ? vdr_pkg::cfg_readback(cfg_q) : '0;
    end
  end

  assign cfg_o = cfg_q;

  p_write_lands_r4: assert property (@(posedge clk) disable iff (!rst_n)
    wr_hit |=> cfg_o == $past(wdata[CW-1:0]));
  p_miss_silent_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (sel && !hit) |=> (!rvalid && $stable(cfg_o)));
  p_upper_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
    rvalid |-> rdata[DW-1:CW] == '0);
  p_read_timing_r2: assert property (@(posedge clk) disable iff (!rst_n)
    rvalid |-> $past(sel && !wr));
endmodule

// File: rtl/vdr_capture.sv
module vdr_capture #(
  parameter int PW = vdr_pkg::PIX_W,
  parameter int SW = vdr_pkg::SYNC_W
) (
  input  logic          pclk,
  input  logic          rst_n,
  input  logic [PW-1:0] luma_i,
  input  logic [PW-1:0] chroma_i,
  input  logic [SW-1:0] sync_i,
  output logic [PW-1:0] luma_q,
  output logic [PW-1:0] chroma_q,
  output logic [SW-1:0] sync_q,
  output logic          warm_o
);
  always_ff @(posedge pclk or negedge rst_n) begin
    if (!rst_n) begin
      luma_q   <= '0;
      chroma_q <= '0;
      sync_q   <= '0;
      warm_o   <= 1'b0;
    end else begin
      luma_q   <= luma_i;
      chroma_q <= chroma_i;
      sync_q   <= sync_i;
      warm_o   <= 1'b1;
    end
  end
endmodule

// File: rtl/vdr_pin_mux.sv
module vdr_pin_mux #(
  parameter int PW = vdr_pkg::PIX_W,
  parameter int SW = vdr_pkg::SYNC_W,
  parameter int OW = vdr_pkg::PORT_W
) (
  input  vdr_pkg::vdr_cfg_t cfg,
  input  logic              pclk,
  input  logic [PW-1:0]     luma_q,
  input  logic [PW-1:0]     chroma_q,
  input  logic [SW-1:0]     sync_q,
  output logic              clk0,
  output logic              clk0_oe,
  output logic              clk1,
  output logic              clk1_oe,
  output logic [SW-1:0]     ctrl,
  output logic [SW-1:0]     ctrl_oe,
  output logic [OW-1:0]     data
);
  localparam logic [SW-1:0] FIXED_VAL = {{(SW-2){1'b0}}, 2'b11};
  localparam logic [SW-1:0] FIXED_OE  = {{(SW-2){1'b0}}, 2'b11};

  assign clk0    = cfg.clk_dir ? 1'b0 : pclk;
  assign clk1    = cfg.clk_dir ? 1'b0 : pclk;
  assign clk0_oe = !cfg.clk_dir;
  assign clk1_oe = !cfg.clk_dir;

  always_comb begin
    if (cfg.ctrl_dir) begin
      ctrl    = FIXED_VAL;
      ctrl_oe = FIXED_OE;
    end else begin
      ctrl    = sync_q;
      ctrl_oe = '1;
    end
  end

  assign data = vdr_pkg::pack_port(chroma_q, luma_q);
endmodule

// File: rtl/vid_dec_router.sv
module vid_dec_router #(
  parameter logic [31:0] REG_ADDR = 32'hA00E_0000
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        bus_sel,
  input  logic        bus_wr,
  input  logic [31:0] bus_addr,
  input  logic [31:0] bus_wdata,
  output logic [31:0] bus_rdata,
  output logic        bus_rvalid,
  input  logic        dec_pclk,
  input  logic [7:0]  dec_luma,
  input  logic [7:0]  dec_chroma,
  input  logic        dec_hsync,
  input  logic        dec_vsync,
  input  logic        dec_odd,
  output logic        dec_reset,
  output logic        port_clk0,
  output logic        port_clk0_oe,
  output logic        port_clk1,
  output logic        port_clk1_oe,
  output logic [2:0]  port_ctrl,
  output logic [2:0]  port_ctrl_oe,
  output logic [19:0] port_data
);
  import vdr_pkg::*;

  logic [CFG_W-1:0]  cfg_bits;
  vdr_cfg_t          cfg;
  logic [PIX_W-1:0]  luma_q, chroma_q;
  logic [SYNC_W-1:0] sync_q;
  logic              cap_warm;

  vdr_ctrl_reg #(.AW(32), .DW(32), .CW(CFG_W), .BASE(REG_ADDR), .RST_VAL(3'b001)) u_reg (
    .clk(clk), .rst_n(rst_n), .sel(bus_sel), .wr(bus_wr), .addr(bus_addr),
    .wdata(bus_wdata), .cfg_o(cfg_bits), .rdata(bus_rdata), .rvalid(bus_rvalid)
  );

  assign cfg       = vdr_cfg_t'(cfg_bits);
  assign dec_reset = cfg.dec_rst;

  vdr_capture #(.PW(PIX_W), .SW(SYNC_W)) u_cap (
    .pclk(dec_pclk), .rst_n(rst_n), .luma_i(dec_luma), .chroma_i(dec_chroma),
    .sync_i({dec_odd, dec_vsync, dec_hsync}),
    .luma_q(luma_q), .chroma_q(chroma_q), .sync_q(sync_q), .warm_o(cap_warm)
  );

  vdr_pin_mux #(.PW(PIX_W), .SW(SYNC_W), .OW(PORT_W)) u_mux (
    .cfg(cfg), .pclk(dec_pclk), .luma_q(luma_q), .chroma_q(chroma_q), .sync_q(sync_q),
    .clk0(port_clk0), .clk0_oe(port_clk0_oe), .clk1(port_clk1), .clk1_oe(port_clk1_oe),
    .ctrl(port_ctrl), .ctrl_oe(port_ctrl_oe), .data(port_data)
  );

  p_pad_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (port_data[11:10] == 2'b00) && (port_data[1:0] == 2'b00));
  p_clk_float_r5: assert property (@(posedge clk) disable iff (!rst_n)
    cfg.clk_dir |-> (!port_clk0_oe && !port_clk1_oe));
  p_fixed_ctrl_r7: assert property (@(posedge clk) disable iff (!rst_n)
    cfg.ctrl_dir |-> (port_ctrl_oe == 3'b011 && port_ctrl[1:0] == 2'b11));
  p_luma_path_r9: assert property (@(posedge dec_pclk) disable iff (!rst_n || !cap_warm)
    port_data[9:2] == $past(dec_luma));
  p_chroma_path_r8: assert property (@(posedge dec_pclk) disable iff (!rst_n || !cap_warm)
    port_data[19:12] == $past(dec_chroma));
  p_sync_path_r6: assert property (@(posedge dec_pclk) disable iff (!rst_n || !cap_warm)
    !cfg.ctrl_dir |-> port_ctrl == $past({dec_odd, dec_vsync, dec_hsync}));
endmodule

// File: tb/tb_vid_dec_router.sv
module tb_vid_dec_router;
  localparam int CLK_PERIOD = 10;
  localparam logic [31:0] REG_A = 32'hA00E_0000;

  logic clk, rst_n, bus_sel, bus_wr, bus_rvalid, dec_pclk;
  logic [31:0] bus_addr, bus_wdata, bus_rdata;
  logic [7:0] dec_luma, dec_chroma;
  logic dec_hsync, dec_vsync, dec_odd, dec_reset;
  logic port_clk0, port_clk0_oe, port_clk1, port_clk1_oe;
  logic [2:0] port_ctrl, port_ctrl_oe;
  logic [19:0] port_data;

  int n_cmp = 0, n_bad = 0;
  logic [31:0] exp_q[$];
  string tag_q[$];

  vid_dec_router dut (.*);

  initial begin clk = 0; forever #(CLK_PERIOD/2) clk = ~clk; end
  initial begin
    dec_pclk = 0; #(CLK_PERIOD/2);
    forever begin dec_pclk = 1; #CLK_PERIOD; dec_pclk = 0; #CLK_PERIOD; end
  end

  task automatic report();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    n_cmp++; n_bad++;
    $display("FAIL watchdog: actual=hung expected=done");
    report();
  end

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string req);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Monitor: pops expected read data whenever the design returns a read.
  always @(negedge clk) begin
    if (rst_n && bus_rvalid) begin
      n_cmp++;
      if (exp_q.size() == 0) begin
        n_bad++;
        $display("FAIL R1: actual=unexpected rvalid data %h expected=no read", bus_rdata);
      end else begin
        automatic logic [31:0] e = exp_q.pop_front();
        automatic string t = tag_q.pop_front();
        if (bus_rdata !== e) begin
          n_bad++;
          $display("FAIL %s: actual=%h expected=%h", t, bus_rdata, e);
        end
      end
    end
  end

  task automatic bus_write(input logic [31:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_sel = 1; bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 0; bus_wr = 0;
  endtask

  // Driver: pushes expected value, issues read; monitor compares next cycle.
  task automatic bus_read(input logic [31:0] exp, input string req);
    exp_q.push_back(exp); tag_q.push_back(req);
    @(negedge clk);
    bus_sel = 1; bus_wr = 0; bus_addr = REG_A;
    @(negedge clk);
    bus_sel = 0;
    chk({31'b0, bus_rvalid}, 32'd1, {req, " rvalid"});
    @(negedge clk);
    chk({31'b0, bus_rvalid}, 32'd0, {req, " rvalid one cycle"});
  endtask

  task automatic bus_read_miss(input logic [31:0] a);
    @(negedge clk);
    bus_sel = 1; bus_wr = 0; bus_addr = a;
    @(negedge clk);
    bus_sel = 0;
    chk({31'b0, bus_rvalid}, 32'd0, "R1 miss read");
  endtask

  function automatic logic [19:0] exp_word(input logic [7:0] c, input logic [7:0] y);
    return (20'(c) << 12) | (20'(y) << 2);
  endfunction

  task automatic pixel_step(input logic [7:0] y, input logic [7:0] c, input logic [2:0] s,
                            input logic ctrl_fixed);
    logic [19:0] old_word;
    logic [2:0]  old_ctrl;
    @(posedge dec_pclk); #3;
    old_word = port_data; old_ctrl = port_ctrl;
    dec_luma = y; dec_chroma = c; {dec_odd, dec_vsync, dec_hsync} = s;
    #5;
    chk({12'b0, port_data}, {12'b0, old_word}, "R9 hold before edge");
    chk({29'b0, port_ctrl}, {29'b0, old_ctrl}, "R9 ctrl hold before edge");
    @(posedge dec_pclk); #3;
    chk({12'b0, port_data}, {12'b0, exp_word(c, y)}, "R8 packed word");
    if (!ctrl_fixed) begin
      chk({29'b0, port_ctrl}, {29'b0, s}, "R6 sync routing");
      chk({29'b0, port_ctrl_oe}, 32'd7, "R6 ctrl enables");
    end
  endtask

  initial begin
    rst_n = 0; bus_sel = 0; bus_wr = 0; bus_addr = 0; bus_wdata = 0;
    dec_luma = 8'h11; dec_chroma = 8'h22; dec_hsync = 1; dec_vsync = 1; dec_odd = 1;
    repeat (3) @(negedge clk);
    chk({31'b0, dec_reset}, 32'd1, "R3 reset dec_reset");
    chk({12'b0, port_data}, 32'd0, "R3 reset port_data");
    chk({30'b0, port_clk1_oe, port_clk0_oe}, 32'd3, "R3 reset clk enables");
    chk({29'b0, port_ctrl_oe}, 32'd7, "R3 reset ctrl enables");
    rst_n = 1;
    bus_read(32'h1, "R3 reset readback");

    // R10 upper write bits ignored, R4 reset bit follows
    bus_write(REG_A | 32'h3, 32'hFFFF_FFF8);
    chk({31'b0, dec_reset}, 32'd0, "R4 dec_reset release");
    bus_read(32'h0, "R10 upper bits read zero");

    // R1 other addresses ignored
    bus_write(REG_A + 32'h8, 32'h7);
    bus_write(32'hA00D_0000, 32'h7);
    chk({31'b0, dec_reset}, 32'd0, "R1 miss write dec_reset");
    bus_read(32'h0, "R1 miss write no effect");
    bus_read_miss(REG_A + 32'h4);

    // R8 / R9 / R6 several patterns
    pixel_step(8'hA5, 8'h5A, 3'b101, 1'b0);
    pixel_step(8'hFF, 8'h00, 3'b010, 1'b0);
    pixel_step(8'h00, 8'hFF, 3'b111, 1'b0);
    pixel_step(8'h81, 8'h7E, 3'b000, 1'b0);

    // R5 clock pins follow pixel clock
    @(posedge dec_pclk); #2;
    chk({29'b0, port_clk1, port_clk0, port_clk0_oe}, 32'b111, "R5 clocks high");
    @(negedge dec_pclk); #2;
    chk({29'b0, port_clk1, port_clk0, port_clk1_oe}, 32'b001, "R5 clocks low");
    bus_write(REG_A, 32'h2);
    chk({30'b0, port_clk1_oe, port_clk0_oe}, 32'd0, "R5 clocks floated");
    bus_read(32'h2, "R2 readback clk dir");

    // R7 fixed control levels
    bus_write(REG_A, 32'h4);
    chk({29'b0, port_ctrl_oe}, 32'b011, "R7 ctrl enables");
    chk({30'b0, port_ctrl[1:0]}, 32'b11, "R7 ctrl levels");
    chk({30'b0, port_clk1_oe, port_clk0_oe}, 32'd3, "R5 clocks driven again");
    pixel_step(8'h3C, 8'hC3, 3'b000, 1'b1);
    chk({29'b0, port_ctrl_oe}, 32'b011, "R7 ctrl unaffected by sync");
    bus_read(32'h4, "R2 readback ctrl dir");

    // Same edge: routing write and pixel capture coincide (R6, R9)
    @(posedge dec_pclk); @(negedge clk); @(negedge clk);
    bus_sel = 1; bus_wr = 1; bus_addr = REG_A; bus_wdata = 32'h0;
    dec_luma = 8'h6B; dec_chroma = 8'h94; {dec_odd, dec_vsync, dec_hsync} = 3'b110;
    @(negedge clk);
    bus_sel = 0; bus_wr = 0;
    chk({29'b0, port_ctrl}, 32'b110, "R6 same-edge routing and sync");
    chk({29'b0, port_ctrl_oe}, 32'd7, "R6 same-edge enables");
    chk({12'b0, port_data}, {12'b0, exp_word(8'h94, 8'h6B)}, "R9 same-edge data");

    // R4 assert decoder reset again
    bus_write(REG_A, 32'h1);
    chk({31'b0, dec_reset}, 32'd1, "R4 dec_reset assert");
    bus_read(32'h1, "R2 final readback");

    repeat (3) @(negedge clk);
    if (exp_q.size() != 0) begin
      n_cmp++; n_bad++;
      $display("FAIL R2: actual=%0d reads missing expected=0", exp_q.size());
    end
    report();
  end
endmodule